// File: doc/BRIEF.md
# Sliding-Shrinking Sparse Window Finder

For one interval of destination vertices, this block receives a bitmap with one bit per source row. A set bit means that at least one destination in the interval has an edge from that row. The block walks the bitmap and reports a series of compact row ranges, called effectual shards. Only the features of rows inside those ranges then need to be fetched. Shards vary in size, and neither edge of a shard is an empty row.

Each window has a maximum height that is a parameter, normally chosen to match the input-buffer capacity. The window's top slides down, one row per clock, until it lands on an occupied row. The bottom then starts at top plus height minus one, clamped to the last row, and climbs one row per clock until it lands on an occupied row. The resulting pair is offered on a valid/ready output. The next search starts on the row just past the unshrunk bottom.

Once the last row has been passed, a one-cycle done pulse ends the interval. A pulse on `start_i` while the block is idle latches a new bitmap.

Top module: `ssw_shard_finder`

## Requirements
- R1: After reset, `shard_valid_o` and `done_o` are 0.
- R2: Empty rows ahead of a window are skipped. A shard's first row is the lowest occupied row (row r is bit r of the bitmap) at or after the current search row.
- R3: A shard's last row is the highest occupied row within rows first .. first+WIN_H-1.
- R4: The search for the next shard starts at first+WIN_H, which is the row after the unshrunk bottom, even when the reported last row is lower.
- R5: A window that would run past row NUM_ROWS-1 is clamped to that row, so a shard never spans more than WIN_H rows or exceeds the last row.
- R6: While `shard_valid_o` is high and `shard_ready_i` is low, the offered pair is held unchanged and no pair is lost or repeated.
- R7: After the last shard is accepted, `done_o` pulses for exactly one cycle and never together with `shard_valid_o`. An empty bitmap yields done with no shard.
- R8: The scan probes one row per clock. With ready held high, done appears after one cycle per slid row, one per shrink probe, one per emitted pair, plus one final check.
- R9: A `start_i` pulse during a scan is ignored, and the bitmap latched at the start is used until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin an interval; accepted only when idle |
| occ_map_i | input | NUM_ROWS | Row-occupancy bitmap, bit r for row r |
| shard_valid_o | output | 1 | A shard pair is offered |
| shard_ready_i | input | 1 | Consumer accepts the offered pair |
| shard_first_o | output | $clog2(NUM_ROWS) | First row of the shard |
| shard_last_o | output | $clog2(NUM_ROWS) | Last row of the shard |
| done_o | output | 1 | One-cycle pulse when the interval is finished |

## Verification
A wrong search cursor or a wrong window bottom appears at the ports as a wrong first or last row on the very next offered pair. Such a pair is compared against a list built from a behavioural model of the bitmap.

A cursor that advances wrongly after a window also shifts every later shard. It moves the done pulse away from the cycle count the model predicts, and that timing is checked exactly whenever ready is held high.

A lost handshake shows up as a missing or repeated pair at the next transfer. A pair that changes while stalled shows up on the first stalled cycle.

// File: rtl/ssw_pkg.sv
package ssw_pkg;
  typedef enum logic [2:0] {
    SCAN_IDLE,
    SCAN_SLIDE,
    SCAN_SHRINK,
    SCAN_EMIT,
    SCAN_FINISH
  } scan_state_e;
endpackage

// File: rtl/ssw_row_probe.sv
module ssw_row_probe #(
  parameter int NUM_ROWS = 16,
  parameter int IDX_W    = $clog2(NUM_ROWS + 1)
) (
  input  logic [NUM_ROWS-1:0] map_i,
  input  logic [IDX_W-1:0]    idx_i,
  output logic                hit_o
);
  // Row selection; an index past the last row reads as empty.
  always_comb begin
    hit_o = 1'b0;
    for (int r = 0; r < NUM_ROWS; r++) begin
      if (idx_i == IDX_W'(r)) hit_o = map_i[r];
    end
  end
endmodule

// File: rtl/ssw_window_calc.sv
module ssw_window_calc #(
  parameter int NUM_ROWS = 16,
  parameter int WIN_H    = 4,
  parameter int IDX_W    = $clog2(NUM_ROWS + 1)
) (
  input  logic [IDX_W-1:0] top_i,
  output logic [IDX_W-1:0] bot_init_o,
  output logic [IDX_W-1:0] next_cur_o
);
  localparam int SUM_W = IDX_W + 1;
  localparam logic [SUM_W-1:0] H_X = SUM_W'(WIN_H);
  localparam logic [SUM_W-1:0] N_X = SUM_W'(NUM_ROWS);

  logic [SUM_W-1:0] far_row;
  logic             past_end;

  always_comb begin
    far_row    = {1'b0, top_i} + H_X;
    past_end   = far_row > N_X;
    bot_init_o = past_end ? IDX_W'(NUM_ROWS - 1) : IDX_W'(far_row - 1'b1);
    next_cur_o = past_end ? IDX_W'(NUM_ROWS) : IDX_W'(far_row);
  end
endmodule

// File: rtl/ssw_scan_ctrl.sv
module ssw_scan_ctrl
  import ssw_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int WIN_H    = 4,
  parameter int IDX_W    = $clog2(NUM_ROWS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             ready_i,
  input  logic             hit_i,
  input  logic [IDX_W-1:0] bot_init_i,
  input  logic [IDX_W-1:0] next_cur_i,
  output logic [IDX_W-1:0] cur_o,
  output logic [IDX_W-1:0] probe_idx_o,
  output logic [IDX_W-1:0] top_o,
  output logic [IDX_W-1:0] bot_o,
  output logic             accept_o,
  output logic             valid_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] END_ROW = IDX_W'(NUM_ROWS);

  scan_state_e      state_q, state_d;
  logic [IDX_W-1:0] cur_q, cur_d, top_q, top_d, bot_q, bot_d, nxt_q, nxt_d;

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    top_d   = top_q;
    bot_d   = bot_q;
    nxt_d   = nxt_q;
    unique case (state_q)
      SCAN_IDLE: begin
        if (start_i) begin
          state_d = SCAN_SLIDE;
          cur_d   = '0;
        end
      end
      SCAN_SLIDE: begin
        if (cur_q >= END_ROW) begin
          state_d = SCAN_FINISH;
        end else if (hit_i) begin
          top_d   = cur_q;
          bot_d   = bot_init_i;
          nxt_d   = next_cur_i;
          state_d = SCAN_SHRINK;
        end else begin
          cur_d = cur_q + 1'b1;
        end
      end
      SCAN_SHRINK: begin
        if (hit_i) state_d = SCAN_EMIT;
        else       bot_d   = bot_q - 1'b1;
      end
      SCAN_EMIT: begin
        if (ready_i) begin
          cur_d   = nxt_q;
          state_d = SCAN_SLIDE;
        end
      end
      SCAN_FINISH: state_d = SCAN_IDLE;
      default:     state_d = SCAN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SCAN_IDLE;
      cur_q   <= '0;
      top_q   <= '0;
      bot_q   <= '0;
      nxt_q   <= '0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      top_q   <= top_d;
      bot_q   <= bot_d;
      nxt_q   <= nxt_d;
    end
  end

  assign cur_o       = cur_q;
  assign top_o       = top_q;
  assign bot_o       = bot_q;
  assign probe_idx_o = (state_q == SCAN_SHRINK) ? bot_q : cur_q;
  assign accept_o    = (state_q == SCAN_IDLE) && start_i;
  assign valid_o     = (state_q == SCAN_EMIT);
  assign done_o      = (state_q == SCAN_FINISH);
endmodule

// File: rtl/ssw_shard_finder.sv
module ssw_shard_finder #(
  parameter int NUM_ROWS = 16,
  parameter int WIN_H    = 4,
  localparam int ROW_W   = $clog2(NUM_ROWS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic [NUM_ROWS-1:0] occ_map_i,
  output logic                shard_valid_o,
  input  logic                shard_ready_i,
  output logic [ROW_W-1:0]    shard_first_o,
  output logic [ROW_W-1:0]    shard_last_o,
  output logic                done_o
);
  localparam int IDX_W = $clog2(NUM_ROWS + 1);

  logic [NUM_ROWS-1:0] map_q;
  logic [IDX_W-1:0]    cur, probe_idx, top, bot, bot_init, next_cur;
  logic                hit, accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      map_q <= '0;
    else if (accept) map_q <= occ_map_i;
  end

  ssw_row_probe #(.NUM_ROWS(NUM_ROWS), .IDX_W(IDX_W)) u_probe (
    .map_i(map_q), .idx_i(probe_idx), .hit_o(hit)
  );

  ssw_window_calc #(.NUM_ROWS(NUM_ROWS), .WIN_H(WIN_H), .IDX_W(IDX_W)) u_win (
    .top_i(cur), .bot_init_o(bot_init), .next_cur_o(next_cur)
  );

  ssw_scan_ctrl #(.NUM_ROWS(NUM_ROWS), .WIN_H(WIN_H), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .ready_i(shard_ready_i),
    .hit_i(hit), .bot_init_i(bot_init), .next_cur_i(next_cur),
    .cur_o(cur), .probe_idx_o(probe_idx), .top_o(top), .bot_o(bot),
    .accept_o(accept), .valid_o(shard_valid_o), .done_o(done_o)
  );

  assign shard_first_o = ROW_W'(top);
  assign shard_last_o  = ROW_W'(bot);
endmodule

// File: rtl/ssw_shard_finder_checker.sv
module ssw_shard_finder_checker #(
  parameter int NUM_ROWS = 16,
  parameter int WIN_H    = 4,
  parameter int ROW_W    = $clog2(NUM_ROWS)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                shard_valid_o,
  input logic                shard_ready_i,
  input logic [ROW_W-1:0]    shard_first_o,
  input logic [ROW_W-1:0]    shard_last_o,
  input logic                done_o,
  input logic [NUM_ROWS-1:0] map_q
);
  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    shard_valid_o && !shard_ready_i |=> shard_valid_o && $stable(shard_first_o) && $stable(shard_last_o));

  p_edges_occupied_r3: assert property (@(posedge clk) disable iff (!rst_n)
    shard_valid_o |-> map_q[shard_first_o] && map_q[shard_last_o]);

  p_height_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    shard_valid_o |-> (shard_last_o >= shard_first_o) &&
                      (32'(shard_last_o) - 32'(shard_first_o) < WIN_H));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && shard_valid_o));
endmodule

bind ssw_shard_finder ssw_shard_finder_checker #(.NUM_ROWS(NUM_ROWS), .WIN_H(WIN_H)) u_chk (
  .clk(clk), .rst_n(rst_n), .shard_valid_o(shard_valid_o), .shard_ready_i(shard_ready_i),
  .shard_first_o(shard_first_o), .shard_last_o(shard_last_o), .done_o(done_o), .map_q(map_q)
);

// File: tb/ssw_shard_finder_bench.sv
module ssw_shard_finder_bench;
  localparam int NR = 16;
  localparam int WH = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [NR-1:0] occ_map_i = '0;
  logic          shard_ready_i = 1'b1;
  logic          shard_valid_o, done_o;
  logic [3:0]    shard_first_o, shard_last_o;

  int total = 0;
  int bad   = 0;
  int exp_first[$];
  int exp_last[$];

  always #5 clk = ~clk;

  ssw_shard_finder #(.NUM_ROWS(NR), .WIN_H(WH)) u_ssw_shard_finder (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .occ_map_i(occ_map_i),
    .shard_valid_o(shard_valid_o), .shard_ready_i(shard_ready_i),
    .shard_first_o(shard_first_o), .shard_last_o(shard_last_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Behavioural model: fills the expected pair queues, returns busy cycles at full ready.
  function automatic int model(input logic [NR-1:0] m);
    int cyc = 0;
    int cur = 0;
    exp_first.delete();
    exp_last.delete();
    while (cur < NR) begin
      cyc++;
      if (m[cur]) begin
        int bot = (cur + WH - 1 > NR - 1) ? NR - 1 : cur + WH - 1;
        while (!m[bot]) begin cyc++; bot--; end
        cyc += 2;
        exp_first.push_back(cur);
        exp_last.push_back(bot);
        cur = cur + WH;
      end else begin
        cur++;
      end
    end
    return cyc + 1;
  endfunction

  task automatic run_case(input logic [NR-1:0] m, input int mode, input bit poke);
    int  exp_done = model(m) + 1;
    int  k = 0;
    bit  seen = 0;
    bit  stalled = 0;
    int  pf = 0, pl = 0;
    @(negedge clk);
    start_i   = 1'b1;
    occ_map_i = m;
    while (!seen && k < 800) begin
      @(negedge clk);
      k++;
      if (k == 1) start_i = 1'b0;
      if (poke && k == 3) begin start_i = 1'b1; occ_map_i = '1; end
      if (poke && k == 4) start_i = 1'b0;
      case (mode)
        0: shard_ready_i = 1'b1;
        1: shard_ready_i = 1'($urandom_range(0, 1));
        default: shard_ready_i = (k % 4 == 0);
      endcase
      if (stalled) begin
        check(shard_valid_o && shard_first_o == pf && shard_last_o == pl,
              "R6 stall hold", shard_first_o, pf);
      end
      if (shard_valid_o && shard_ready_i) begin
        if (exp_first.size() == 0) begin
          check(0, "R2 unexpected shard", shard_first_o, -1);
        end else begin
          int ef = exp_first.pop_front();
          int el = exp_last.pop_front();
          check(shard_first_o == ef, "R2/R4/R9 first row", shard_first_o, ef);
          check(shard_last_o == el, "R3/R5 last row", shard_last_o, el);
        end
      end
      if (done_o) begin
        seen = 1;
        check(exp_first.size() == 0, "R7 done after last shard", exp_first.size(), 0);
        check(!shard_valid_o, "R7 done without valid", shard_valid_o, 0);
        if (mode == 0) check(k == exp_done, "R8 done cycle", k, exp_done);
      end
      stalled = shard_valid_o && !shard_ready_i;
      pf = shard_first_o;
      pl = shard_last_o;
    end
    check(seen, "R7 watchdog done", k, exp_done);
    @(negedge clk);
    check(!done_o, "R7 one-cycle pulse", done_o, 0);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!shard_valid_o && !done_o, "R1 reset outputs", shard_valid_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!shard_valid_o && !done_o, "R1 idle outputs", done_o, 0);

    run_case(16'h0000, 0, 0);   // R7 empty interval
    run_case(16'hFFFF, 0, 0);   // R2 dense
    run_case(16'h8000, 0, 0);   // R5 single last row
    run_case(16'h0001, 0, 0);   // R3 shrink to top
    run_case(16'hA000, 0, 0);   // R5 clamp: (13,15)
    run_case(16'h0122, 0, 0);   // R4 restart after unshrunk bottom
    run_case(16'h0F0F, 2, 0);   // R6 slow ready
    run_case(16'h1248, 0, 1);   // R9 start ignored mid-scan
    for (int i = 0; i < 60; i++) begin
      logic [NR-1:0] m = NR'($urandom);
      if (i % 3 == 1) m = m & NR'($urandom);
      if (i % 3 == 2) m = m & NR'($urandom) & NR'($urandom);
      run_case(m, i % 3, i % 5 == 0);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule